// File: doc/BRIEF.md
# Bus Event Performance Counter

This block counts events on a PCI-style bus so that software can measure traffic. The bus protocol engine sits outside it and presents one strobe per clock for a decoded bus command, together with its 4-bit command value. It also presents separate strobes for the retry, lock and 64-bit acknowledge signals.

A 6-bit event selector picks what is counted. The selector can name one exact bus command, a grouped class of commands, or one bus signal assertion. The count lives in a 39-bit field, and a sticky overflow flag sits directly above it.

Software writes the count through a dedicated write port. Each write also saves the same value as the reload value. In reload mode an overflow restarts the count from that value. A level interrupt follows the overflow flag while interrupts are enabled.

Top module: `evcnt_top`

## Requirements
- R1: After reset the count read value is zero, the control read value is zero and `irq` is low.
- R2: `cnt_rdata` bits 38:0 carry the count, bit 39 carries the overflow flag, and bits 63:40 always read as zero.
- R3: A count write loads bits 38:0 into the live count and into the reload value, and clears the overflow flag. When a write and an event fall in the same cycle, the write wins and that event is not counted.
- R4: Selector codes with bits 5:4 equal to 00 count bus commands whose 4-bit value equals selector bits 3:0. This holds only for the values 0010, 0011, 0110, 0111, 1100, 1101, 1110 and 1111; the other eight values in this group never count.
- R5: Selector codes 010_xxx count grouped classes. Memory reads are 0110, 1100 and 1110. Memory writes are 0111 and 1111. I/O commands are 0010 (read) and 0011 (write). The low three bits select the class as follows:
  - 000: any command strobe, whatever its value.
  - 001: any memory command.
  - 010: any memory read.
  - 011: any memory write.
  - 100: any I/O command.
  - 101: any I/O or memory command.
  - 110: any I/O or memory read.
  - 111: any I/O or memory write.
- R6: Selector 011_010 counts cycles with retry high, 011_110 counts cycles with lock high, and 011_111 counts cycles with 64-bit acknowledge high. Every other 011_xxx code and every 1x_xxxx code never counts.
- R7: The count advances by at most one per clock, and only while the run bit is set and the selected event is present. With run clear, the count holds.
- R8: An increment from the all-ones count sets the overflow flag. The flag stays set until the next count write. Without reload, the count wraps to zero.
- R9: With reload enabled, the increment that overflows loads the reload value into the count in that same cycle.
- R10: `irq` is high exactly while the overflow flag and the interrupt enable are both set.
- R11: The control word is {selector[5:0] at bits 8:3, interrupt enable at bit 2, reload enable at bit 1, run at bit 0}. A control write takes effect on the next clock and reads back unchanged on `ctl_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cmd_valid | input | 1 | One-cycle strobe for a decoded bus command |
| bus_cmd | input | 4 | Command value qualified by bus_cmd_valid |
| bus_retry | input | 1 | Retry asserted this cycle |
| bus_lock | input | 1 | Lock asserted this cycle |
| bus_ack64 | input | 1 | 64-bit acknowledge asserted this cycle |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 39 | Count write value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 9 | Control write value |
| cnt_rdata | output | 64 | Count read value with the overflow flag |
| ctl_rdata | output | 9 | Control read value |
| irq | output | 1 | Overflow interrupt level |

## Verification
The bench walks every command code under every exact and grouped selector. It then drives the signal selector space, including the reserved codes. A decoder that let a reserved code through, or put a command in the wrong class, would count where the reference model holds still.

The bench also places the count one or two steps below all-ones, with reload both on and off. A carry taken from the wrong bit, a non-sticky flag, or a reload that lands one cycle late would each show up as a wrong bit 39 or a wrong low field. Writes that coincide with events catch a design that lets the increment win. Stopping the counter with events present catches a design that ignores the run bit.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

   localparam int SEL_W = 6;
   localparam int CTL_W = SEL_W + 3;

   localparam logic [3:0] CMD_IORD  = 4'b0010;
   localparam logic [3:0] CMD_IOWR  = 4'b0011;
   localparam logic [3:0] CMD_MRD   = 4'b0110;
   localparam logic [3:0] CMD_MWR   = 4'b0111;
   localparam logic [3:0] CMD_MRDM  = 4'b1100;
   localparam logic [3:0] CMD_DAC   = 4'b1101;
   localparam logic [3:0] CMD_MRDL  = 4'b1110;
   localparam logic [3:0] CMD_MWRI  = 4'b1111;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             irq_en;
      logic             rld_en;
      logic             run;
   } ctl_t;

   function automatic logic cmd_known(input logic [3:0] c);
      return (c == CMD_IORD) || (c == CMD_IOWR) || (c == CMD_MRD) ||
             (c == CMD_MWR)  || (c == CMD_MRDM) || (c == CMD_DAC) ||
             (c == CMD_MRDL) || (c == CMD_MWRI);
   endfunction

   function automatic logic is_mrd(input logic [3:0] c);
      return (c == CMD_MRD) || (c == CMD_MRDM) || (c == CMD_MRDL);
   endfunction

   function automatic logic is_mwr(input logic [3:0] c);
      return (c == CMD_MWR) || (c == CMD_MWRI);
   endfunction

endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
   import evcnt_pkg::*;
(
   input  logic [SEL_W-1:0] sel,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd,
   input  logic             retry,
   input  logic             lock,
   input  logic             ack64,
   output logic             hit
);

   logic       io_rd, io_wr, m_rd, m_wr;
   logic [7:0] class_vec;
   logic [7:0] sig_vec;

   assign io_rd = (cmd == CMD_IORD);
   assign io_wr = (cmd == CMD_IOWR);
   assign m_rd  = is_mrd(cmd);
   assign m_wr  = is_mwr(cmd);

   // class table indexed by selector bits 2:0
   assign class_vec[0] = 1'b1;
   assign class_vec[1] = m_rd | m_wr;
   assign class_vec[2] = m_rd;
   assign class_vec[3] = m_wr;
   assign class_vec[4] = io_rd | io_wr;
   assign class_vec[5] = io_rd | io_wr | m_rd | m_wr;
   assign class_vec[6] = io_rd | m_rd;
   assign class_vec[7] = io_wr | m_wr;

   // signal table: only three slots are live
   assign sig_vec = {ack64, lock, 3'b000, retry, 2'b00};

   always_comb begin
      hit = 1'b0;
      if (sel[5:4] == 2'b00)
         hit = cmd_valid && (cmd == sel[3:0]) && cmd_known(sel[3:0]);
      else if (sel[5:3] == 3'b010)
         hit = cmd_valid && class_vec[sel[2:0]];
      else if (sel[5:3] == 3'b011)
         hit = sig_vec[sel[2:0]];
   end

endmodule

// File: rtl/evcnt_ctlreg.sv
module evcnt_ctlreg
   import evcnt_pkg::*;
#(
   parameter bit HAS_RELOAD = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl
);

   ctl_t ctl_q;

   generate
      if (HAS_RELOAD) begin : g_rld
         always_ff @(posedge clk) begin
            if (!rst_n)  ctl_q <= '0;
            else if (wr) ctl_q <= ctl_t'(wdata);
         end
      end else begin : g_norld
         always_ff @(posedge clk) begin
            if (!rst_n)  ctl_q <= '0;
            else if (wr) ctl_q <= ctl_t'({wdata[CTL_W-1:2], 1'b0, wdata[0]});
         end
      end
   endgenerate

   assign ctl = ctl_q;

   assert_ctl_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (ctl_q.sel == $past(wdata[CTL_W-1:3])) && (ctl_q.run == $past(wdata[0])));

endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
   parameter int CNT_W      = 39,
   parameter bit HAS_RELOAD = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             inc,
   input  logic             rld_en,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_val;
   logic             ovf_q;
   logic             carry;

   assign carry = inc && (cnt_q == CNT_MAX);

   generate
      if (HAS_RELOAD) begin : g_rld
         logic [CNT_W-1:0] rld_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  rld_q <= '0;
            else if (ld) rld_q <= ld_val;
         end
         assign wrap_val = rld_en ? rld_q : '0;

         assert_reload_on_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (carry && !ld && rld_en) |=> (cnt_q == rld_q));
      end else begin : g_norld
         assign wrap_val = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (ld) begin
         cnt_q <= ld_val;
         ovf_q <= 1'b0;
      end else if (carry) begin
         cnt_q <= wrap_val;
         ovf_q <= 1'b1;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ld) |=> ovf_q);
   assert_carry_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && (cnt_q == CNT_MAX) && !ld) |=> ovf_q);
   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld) |=> $stable(cnt_q));
   assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(ld_val)) && !ovf_q);

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
   import evcnt_pkg::*;
#(
   parameter int CNT_W      = 39,
   parameter int RD_W       = 64,
   parameter bit HAS_RELOAD = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_cmd_valid,
   input  logic [3:0]       bus_cmd,
   input  logic             bus_retry,
   input  logic             bus_lock,
   input  logic             bus_ack64,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [RD_W-1:0]  cnt_rdata,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             irq
);

   generate
      if (CNT_W < 4 || CNT_W > 62) begin : g_bad_cnt
         $error("evcnt_top: CNT_W must lie in 4..62");
      end
      if (RD_W < CNT_W + 1) begin : g_bad_rd
         $error("evcnt_top: RD_W must hold the count and the overflow flag");
      end
   endgenerate

   ctl_t             ctl;
   logic             hit;
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   evcnt_ctlreg #(.HAS_RELOAD(HAS_RELOAD)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .ctl   (ctl)
   );

   evcnt_decode u_dec (
      .sel       (ctl.sel),
      .cmd_valid (bus_cmd_valid),
      .cmd       (bus_cmd),
      .retry     (bus_retry),
      .lock      (bus_lock),
      .ack64     (bus_ack64),
      .hit       (hit)
   );

   evcnt_core #(.CNT_W(CNT_W), .HAS_RELOAD(HAS_RELOAD)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cnt_wr),
      .ld_val (cnt_wdata),
      .inc    (ctl.run && hit),
      .rld_en (ctl.rld_en),
      .cnt    (cnt),
      .ovf    (ovf)
   );

   assign cnt_rdata = RD_W'({ovf, cnt});
   assign ctl_rdata = ctl;
   assign irq       = ovf && ctl.irq_en;

   assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.run && !cnt_wr) |=> $stable(cnt_rdata));
   assert_reserved_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.sel[5] |-> !hit);
   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[2] |-> !irq);
   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rdata[RD_W-1:CNT_W+1] == '0);

endmodule

// File: tb/tb_evcnt_top.sv
`timescale 1ns/1ps
module tb_evcnt_top;

   localparam int CNT_W = 39;
   localparam logic [CNT_W-1:0] MAXC = '1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             bus_cmd_valid;
   logic [3:0]       bus_cmd;
   logic             bus_retry, bus_lock, bus_ack64;
   logic             cnt_wr;
   logic [CNT_W-1:0] cnt_wdata;
   logic             ctl_wr;
   logic [8:0]       ctl_wdata;
   logic [63:0]      cnt_rdata;
   logic [8:0]       ctl_rdata;
   logic             irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [CNT_W-1:0] m_cnt, m_rld;
   logic             m_ovf;
   logic [8:0]       m_ctl;

   always #2.5 clk = ~clk;

   evcnt_top dut (
      .clk(clk), .rst_n(rst_n),
      .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd),
      .bus_retry(bus_retry), .bus_lock(bus_lock), .bus_ack64(bus_ack64),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .cnt_rdata(cnt_rdata), .ctl_rdata(ctl_rdata), .irq(irq)
   );

   function automatic bit exp_hit(input logic [5:0] s, input logic v, input logic [3:0] c,
                                  input logic rt, input logic lk, input logic ak);
      bit mr, mw, ir, iw;
      mr = (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
      mw = (c == 4'b0111) || (c == 4'b1111);
      ir = (c == 4'b0010);
      iw = (c == 4'b0011);
      if (s[5:4] == 2'b00)
         return v && (c == s[3:0]) && (s[3:0] inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hD, 4'hE, 4'hF});
      if (s[5:3] == 3'b010) begin
         case (s[2:0])
            3'd0: return v;
            3'd1: return v && (mr || mw);
            3'd2: return v && mr;
            3'd3: return v && mw;
            3'd4: return v && (ir || iw);
            3'd5: return v && (ir || iw || mr || mw);
            3'd6: return v && (ir || mr);
            default: return v && (iw || mw);
         endcase
      end
      if (s == 6'b011010) return rt;
      if (s == 6'b011110) return lk;
      if (s == 6'b011111) return ak;
      return 1'b0;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, cnt_rdata, {24'b0, m_ovf, m_cnt});
      chk("R11", {55'b0, ctl_rdata}, {55'b0, m_ctl});
      chk("R10", {63'b0, irq}, {63'b0, m_ovf & m_ctl[2]});
   endtask

   task automatic idle_inputs();
      bus_cmd_valid = 0; bus_cmd = 0; bus_retry = 0; bus_lock = 0; bus_ack64 = 0;
      cnt_wr = 0; cnt_wdata = 0; ctl_wr = 0; ctl_wdata = 0;
   endtask

   // model next state from the inputs now driven, then advance one clock
   task automatic step(input string tag);
      bit h;
      h = exp_hit(m_ctl[8:3], bus_cmd_valid, bus_cmd, bus_retry, bus_lock, bus_ack64);
      if (cnt_wr) begin
         m_cnt = cnt_wdata; m_rld = cnt_wdata; m_ovf = 1'b0;
      end else if (m_ctl[0] && h) begin
         if (m_cnt == MAXC) begin
            m_ovf = 1'b1;
            m_cnt = m_ctl[1] ? m_rld : '0;
         end else m_cnt = m_cnt + 1'b1;
      end
      if (ctl_wr) m_ctl = ctl_wdata;
      @(negedge clk);
      idle_inputs();
      compare_all(tag);
   endtask

   task automatic set_ctl(input logic [5:0] s, input bit ie, input bit re, input bit rn, input string tag);
      ctl_wr = 1; ctl_wdata = {s, ie, re, rn};
      step(tag);
   endtask

   task automatic set_cnt(input logic [CNT_W-1:0] v, input string tag);
      cnt_wr = 1; cnt_wdata = v;
      step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_inputs();
      rst_n = 0;
      m_cnt = '0; m_rld = '0; m_ovf = 0; m_ctl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      compare_all("R1");

      // R11 control readback, R3 load, write beats event
      set_ctl(6'b010000, 1, 1, 1, "R11");
      set_cnt(MAXC - 1, "R3");
      cnt_wr = 1; cnt_wdata = MAXC - 1; bus_cmd_valid = 1; step("R3");
      // R8 reach all-ones, R9 overflow with reload, R10 interrupt
      bus_cmd_valid = 1; step("R8");
      bus_cmd_valid = 1; step("R9");
      bus_cmd_valid = 1; step("R8");
      // R10 mask the interrupt, R3 write clears overflow
      set_ctl(6'b010000, 0, 1, 1, "R10");
      set_cnt('0, "R3");

      // R4 exact commands over all selector and command values
      for (int s = 0; s < 16; s++) begin
         set_ctl({2'b00, 4'(s)}, 0, 0, 1, "R4");
         for (int c = 0; c < 16; c++) begin
            bus_cmd_valid = 1; bus_cmd = 4'(c); step("R4");
         end
      end
      // R5 grouped classes
      for (int k = 0; k < 8; k++) begin
         set_ctl({3'b010, 3'(k)}, 0, 0, 1, "R5");
         for (int c = 0; c < 16; c++) begin
            bus_cmd_valid = 1; bus_cmd = 4'(c); step("R5");
         end
         step("R5");
      end
      // R6 signals and reserved codes
      for (int s = 24; s < 64; s++) begin
         set_ctl(6'(s), 0, 0, 1, "R6");
         bus_retry = 1; step("R6");
         bus_lock = 1; step("R6");
         bus_ack64 = 1; step("R6");
         bus_retry = 1; bus_lock = 1; bus_ack64 = 1; bus_cmd_valid = 1; step("R6");
      end
      // R7 stopped counter ignores events
      set_ctl(6'b010000, 0, 0, 0, "R7");
      for (int i = 0; i < 5; i++) begin
         bus_cmd_valid = 1; bus_retry = 1; step("R7");
      end
      // R8 wrap without reload and sticky flag
      set_ctl(6'b010000, 1, 0, 1, "R8");
      set_cnt(MAXC, "R8");
      bus_cmd_valid = 1; step("R8");
      for (int i = 0; i < 4; i++) begin
         bus_cmd_valid = 1; step("R8");
      end
      set_cnt(5, "R3");

      // R2 constrained random mix
      for (int i = 0; i < 6000; i++) begin
         bus_cmd_valid = ($urandom % 2) != 0;
         bus_cmd = 4'($urandom);
         bus_retry = ($urandom % 3) == 0;
         bus_lock = ($urandom % 3) == 0;
         bus_ack64 = ($urandom % 3) == 0;
         if (($urandom % 40) == 0) begin
            cnt_wr = 1;
            if ($urandom % 2) cnt_wdata = MAXC - CNT_W'($urandom % 4);
            else cnt_wdata = CNT_W'({$urandom, $urandom});
         end
         if (($urandom % 60) == 0) begin
            ctl_wr = 1;
            ctl_wdata = {6'($urandom), 3'($urandom)};
            if (($urandom % 4) != 0) ctl_wdata[0] = 1'b1;
         end
         step("R2");
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule